// File: doc/BRIEF.md
# Three-Sample Agreement Debounce Filter

This block cleans up a single noisy bit. On every clock in which the sample-enable input is high, it takes one sample of the raw input and compares it with the current filtered level. A sample that matches the filtered level clears any partial progress. A sample that differs adds one to a disagreement run. When a third disagreeing sample in a row arrives, the filtered level flips to the new value and the run starts again from zero. A lone glitch, or two glitches in a row, therefore never reaches the output.

The filter is a six-state machine, with one state for each pair of held level (1 or 0) and disagreement run (0, 1 or 2). The state names are:

- `ONE_QUIET`: level 1, run 0.
- `ONE_DOUBT1`: level 1, one 0 seen.
- `ONE_DOUBT2`: level 1, two 0s seen.
- `ZERO_QUIET`: level 0, run 0.
- `ZERO_DOUBT1`: level 0, one 1 seen.
- `ZERO_DOUBT2`: level 0, two 1s seen.

The machine takes these transitions on an accepted sample:

- advance: QUIET to DOUBT1, or DOUBT1 to DOUBT2, on a disagreeing sample.
- flip: DOUBT2 to the opposite QUIET state, on a disagreeing sample.
- settle: any state back to its own QUIET state, on an agreeing sample.
- stay: the state does not change while sample-enable is low.

Synchronous reset enters `ONE_QUIET`. The input is expected to be synchronised already, and the caller chooses the sample rate through the enable.

Top module: `tri_agree_filter`

## Requirements
- R1: While reset is high at a clock edge, the next cycle shows `filt_out` = 1 and `change_pulse` = 0, and the disagreement run is zero. This holds both at start-up and when reset is applied during operation.
- R2: When a third consecutive accepted sample differs from `filt_out`, `filt_out` takes that sample's value in the cycle that follows the clock edge at which the sample was accepted.
- R3: An accepted sample equal to `filt_out` clears the disagreement run. For example, the samples 0,0,1,0,0 taken from level 1 leave the output at 1.
- R4: One or two consecutive disagreeing samples leave `filt_out` unchanged.
- R5: While `sample_en` is low, `filt_out` and the disagreement run both hold, whatever the value of `raw_in`.
- R6: `change_pulse` is high for exactly the one cycle in which `filt_out` shows a new value, and is low at all other times.
- R7: From reset, the accepted samples 1 0 0 1 0 1 0 0 0 1 0 1 1 1 produce the output sequence 1 1 1 1 1 1 1 1 0 0 0 0 0 1, one output per sample.
- R8: Strictly alternating samples never change `filt_out`, whether the level is 1 or 0.
- R9: The filter switches in both directions by the same rule: three 1s move the output from 0 to 1, and three 0s move it from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | High when `raw_in` is to be sampled this cycle |
| raw_in | input | 1 | Raw input bit, already synchronised |
| filt_out | output | 1 | Filtered level, registered |
| change_pulse | output | 1 | One-cycle pulse in the cycle that `filt_out` changes |

## Verification
The bench targets the points where a counting filter usually goes wrong:

- **Run not cleared.** An agreeing sample placed between disagreeing ones would let a design that forgets to clear the run flip the output too early.
- **Run cleared while idle.** Disabled cycles placed inside a disagreement run would catch a design that clears or advances the run when `sample_en` is low.
- **Wrong flip cycle.** Switching one sample too early or too late breaks the stated 14-sample sequence.
- **Alternating input.** An alternating stream would make a filter that counts disagreements without resetting the run toggle.
- **Pulse faults.** A mis-timed or stretched `change_pulse` shows as a mismatch against the cycle in which the level changes.
- **Mid-run reset.** Asserting reset while the output is 0 shows whether reset really forces the output back to 1.

// File: rtl/tri_agree_pkg.sv
package tri_agree_pkg;

    // Bit 2 is the held level; bits 1:0 are the disagreement run.
    typedef enum logic [2:0] {
        ZERO_QUIET  = 3'b000,
        ZERO_DOUBT1 = 3'b001,
        ZERO_DOUBT2 = 3'b010,
        ONE_QUIET   = 3'b100,
        ONE_DOUBT1  = 3'b101,
        ONE_DOUBT2  = 3'b110
    } filt_state_t;

    localparam filt_state_t RESET_STATE = ONE_QUIET;
    localparam logic        RESET_LEVEL = 1'b1;

endpackage

// File: rtl/tri_agree_next.sv
module tri_agree_next
    import tri_agree_pkg::*;
(
    input  filt_state_t cur_state,
    input  logic        sample_en,
    input  logic        raw_in,
    output filt_state_t nxt_state
);

    always_comb begin
        nxt_state = cur_state;
        if (sample_en) begin
            unique case (cur_state)
                ONE_QUIET:   nxt_state = raw_in ? ONE_QUIET  : ONE_DOUBT1;
                ONE_DOUBT1:  nxt_state = raw_in ? ONE_QUIET  : ONE_DOUBT2;
                ONE_DOUBT2:  nxt_state = raw_in ? ONE_QUIET  : ZERO_QUIET;
                ZERO_QUIET:  nxt_state = raw_in ? ZERO_DOUBT1 : ZERO_QUIET;
                ZERO_DOUBT1: nxt_state = raw_in ? ZERO_DOUBT2 : ZERO_QUIET;
                ZERO_DOUBT2: nxt_state = raw_in ? ONE_QUIET   : ZERO_QUIET;
                default:     nxt_state = RESET_STATE;
            endcase
        end
    end

endmodule

// File: rtl/tri_agree_level.sv
module tri_agree_level
    import tri_agree_pkg::*;
(
    input  filt_state_t state,
    output logic        level
);

    always_comb begin
        unique case (state)
            ONE_QUIET, ONE_DOUBT1, ONE_DOUBT2:    level = 1'b1;
            ZERO_QUIET, ZERO_DOUBT1, ZERO_DOUBT2: level = 1'b0;
            default:                              level = RESET_LEVEL;
        endcase
    end

endmodule

// File: rtl/tri_agree_filter.sv
module tri_agree_filter
    import tri_agree_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic raw_in,
    output logic filt_out,
    output logic change_pulse
);

    filt_state_t state_q;
    filt_state_t state_d;
    logic        level_d;

    tri_agree_next u_next (
        .cur_state (state_q),
        .sample_en (sample_en),
        .raw_in    (raw_in),
        .nxt_state (state_d)
    );

    tri_agree_level u_level (
        .state (state_d),
        .level (level_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: level and change pulse land in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            filt_out     <= RESET_LEVEL;
            change_pulse <= 1'b0;
        end else begin
            filt_out     <= level_d;
            change_pulse <= (level_d != filt_out);
        end
    end

endmodule

// File: rtl/tri_agree_checks.sv
module tri_agree_checks (
    input logic clk,
    input logic rst,
    input logic sample_en,
    input logic raw_in,
    input logic filt_out,
    input logic change_pulse
);

    // Independent tally of consecutive accepted disagreements
    logic [1:0] dis_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_run <= 2'd0;
        end else if (sample_en) begin
            if (raw_in == filt_out || dis_run == 2'd2) begin
                dis_run <= 2'd0;
            end else begin
                dis_run <= dis_run + 2'd1;
            end
        end
    end

    assert_reset_high_R1: assert property (@(posedge clk)
        rst |=> (filt_out && !change_pulse));

    assert_third_switch_R2: assert property (@(posedge clk) disable iff (rst)
        (sample_en && raw_in != filt_out && dis_run == 2'd2) |=> (filt_out != $past(filt_out)));

    assert_agree_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (sample_en && raw_in == filt_out) |=> $stable(filt_out));

    assert_early_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (sample_en && raw_in != filt_out && dis_run != 2'd2) |=> $stable(filt_out));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> ($stable(filt_out) && !change_pulse));

    assert_pulse_match_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (change_pulse == (filt_out != $past(filt_out))));

endmodule

bind tri_agree_filter tri_agree_checks u_chk (.*);

// File: tb/test_tri_agree_filter.sv
module test_tri_agree_filter;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_en = 1'b0;
    logic raw_in = 1'b1;
    logic filt_out;
    logic change_pulse;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference
    int m_out = 1;
    int m_run = 0;
    int m_prev = 1;

    always #2 clk = ~clk;

    tri_agree_filter i_tri_agree_filter (
        .clk          (clk),
        .rst          (rst),
        .sample_en    (sample_en),
        .raw_in       (raw_in),
        .filt_out     (filt_out),
        .change_pulse (change_pulse)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        sample_en = 1'b0;
        @(posedge clk);
        #1;
        m_out = 1; m_run = 0; m_prev = 1;
        check(filt_out, 1'b1, {tag, " level"});
        check(change_pulse, 1'b0, {tag, " pulse"});
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic en, input logic d, input string tag);
        @(negedge clk);
        sample_en = en;
        raw_in = d;
        @(posedge clk);
        m_prev = m_out;
        if (en) begin
            if (int'(d) == m_out) m_run = 0;
            else if (m_run < 2) m_run++;
            else begin m_out = int'(d); m_run = 0; end
        end
        #1;
        check(filt_out, logic'(m_out), {tag, " level"});
        check(change_pulse, logic'(m_out != m_prev), {tag, " pulse"});
    endtask

    initial begin
        logic [13:0] seq_in;
        logic [13:0] seq_out;
        seq_in  = 14'b10010100010111;
        seq_out = 14'b11111111000001;

        // R1: start-up reset
        do_reset("R1 startup");

        // R7: stated sequence against literal expectations
        for (int i = 13; i >= 0; i--) begin
            step(1'b1, seq_in[i], "R7 model");
            check(filt_out, seq_out[i], "R7 literal");
        end

        // R8: alternation at level 1
        for (int i = 0; i < 20; i++) step(1'b1, logic'(i % 2 == 0 ? 0 : 1), "R8 alt@1");
        check(filt_out, 1'b1, "R8 alt@1 final");

        // R3: agreeing sample clears run
        step(1'b1, 1'b0, "R3"); step(1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, "R3");
        step(1'b1, 1'b0, "R3"); step(1'b1, 1'b0, "R3");
        check(filt_out, 1'b1, "R3 still high");

        // R4: two disagreements then agreement
        step(1'b1, 1'b1, "R4");
        step(1'b1, 1'b0, "R4"); check(filt_out, 1'b1, "R4 one");
        step(1'b1, 1'b0, "R4"); check(filt_out, 1'b1, "R4 two");
        step(1'b1, 1'b1, "R4");

        // R5: idle cycles inside a run neither clear nor advance
        step(1'b1, 1'b0, "R5"); step(1'b1, 1'b0, "R5");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R5 idle one");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R5 idle zero");
        check(filt_out, 1'b1, "R5 held");
        step(1'b1, 1'b0, "R5 third");
        check(filt_out, 1'b0, "R5 switched");
        check(change_pulse, 1'b1, "R6 pulse on switch");
        step(1'b1, 1'b0, "R6");
        check(change_pulse, 1'b0, "R6 pulse drops");

        // R8: alternation at level 0
        for (int i = 0; i < 20; i++) step(1'b1, logic'(i % 2 == 0 ? 1 : 0), "R8 alt@0");
        check(filt_out, 1'b0, "R8 alt@0 final");

        // R9 / R2: rising switch on third 1
        step(1'b1, 1'b1, "R9"); step(1'b1, 1'b1, "R9");
        check(filt_out, 1'b0, "R2 not yet");
        step(1'b1, 1'b1, "R9");
        check(filt_out, 1'b1, "R9 rise");
        check(change_pulse, 1'b1, "R6 rise pulse");

        // Drive low again, then reset mid-run
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R9 fall");
        check(filt_out, 1'b0, "R9 fall");
        step(1'b1, 1'b1, "R1 pre");
        do_reset("R1 midrun");
        step(1'b1, 1'b0, "R1 run cleared"); step(1'b1, 1'b0, "R1 run cleared");
        check(filt_out, 1'b1, "R1 run cleared");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule